// File: doc/BRIEF.md
# Compare Flag and Signed-Branch Unit

This unit produces the condition flags for the compare and subtract-with-borrow instructions of an 8-bit accumulator processor. Each cycle it can accept one operation class and two operands. It forms the difference without writing any register back, and loads negative (N), overflow (V), zero (Z) and carry (C) into a small flag register. The unsigned and signed branch conditions come combinationally from the stored flags. A loop or branch stage can therefore test ordering one cycle after the operation is issued.

A configuration input selects how an accumulator compare treats V. In legacy mode it leaves V unchanged. In extended mode it sets V the way subtraction does, and a dedicated signed-compare class always does so. Index-register compares never touch V, so an overflow carried across a counted loop survives the loop test. A set-overflow pin forces V to 1 whatever the instruction stream is doing.

Top module: `cmp_flag_unit`

## Requirements
- R1: For a compare class (op_class 0, 1, 2 or 4 with op_valid high), the flags after the next rising edge hold Z = 1 exactly when the operands are equal and N = bit 7 of (opnd_a − opnd_b) mod 256; carry_in has no effect.
- R2: For a compare class, C after the next edge is 1 exactly when opnd_a ≥ opnd_b as unsigned numbers.
- R3: An accumulator compare (op_class 0) with ovf_on_acc_cmp low leaves V at its previous value.
- R4: An accumulator compare with ovf_on_acc_cmp high, and a signed compare (op_class 4) in either mode, set V to the two's-complement overflow of opnd_a − opnd_b. V is 1 when the operand signs differ and the result sign differs from opnd_a.
- R5: Index compares (op_class 1 and 2) never change V, whatever ovf_on_acc_cmp is.
- R6: Subtract (op_class 3) computes opnd_a − opnd_b − (1 − carry_in) and updates N, Z, V and C. C = 1 means no borrow.
- R7: set_ovf high at a rising edge makes V = 1 after that edge. This takes priority over any instruction that writes V in the same cycle, and the other flags still update normally.
- R8: br_slt = N XOR V and br_sge is its inverse.
- R9: br_sle = (N XOR V) OR Z and br_sgt is its inverse.
- R10: br_ult = NOT C and br_uge = C.
- R11: Reset (rst_n low) clears all four flags to 0. With op_valid low, or op_class 5 to 7, the flags hold (apart from R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | 0 acc compare, 1 X compare, 2 Y compare, 3 subtract, 4 signed compare |
| opnd_a | input | 8 | Minuend (register value) |
| opnd_b | input | 8 | Subtrahend (memory operand) |
| carry_in | input | 1 | Current carry, used only by subtract |
| ovf_on_acc_cmp | input | 1 | 1 = accumulator compare updates V |
| set_ovf | input | 1 | External request to force V to 1 |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| br_ult | output | 1 | Unsigned less-than |
| br_uge | output | 1 | Unsigned greater-or-equal |
| br_slt | output | 1 | Signed less-than |
| br_sge | output | 1 | Signed greater-or-equal |
| br_sle | output | 1 | Signed less-or-equal |
| br_sgt | output | 1 | Signed greater-than |

## Verification
The flag register is the only state, so a wrong write mask or a wrong next-flag value is visible on the flag outputs one edge after the operation. It also reaches all six branch outputs in the same cycle. Wrong V handling is the subtle case: it shows up only when the earlier V differs from what the current subtraction would give. For that reason every vector first loads a chosen V, then compares the result against that held value. The pin-priority case issues a subtract that clears V in the same cycle as the pin.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [2:0] {
    OP_CMP_ACC = 3'd0,
    OP_CMP_X   = 3'd1,
    OP_CMP_Y   = 3'd2,
    OP_SUB_BRW = 3'd3,
    OP_CMP_SGN = 3'd4
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/cfu_sub_core.sv
module cfu_sub_core #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output cfu_pkg::flags_t res
);
  localparam int MSB = DW - 1;

  // a - b - !cin as a + ~b + cin, carry out = no borrow
  function automatic logic [DW:0] sub_ext(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          ci);
    return {1'b0, x} + {1'b0, ~y} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic sub_ovf(input logic [DW-1:0] x,
                                   input logic [DW-1:0] y,
                                   input logic [DW-1:0] d);
    return (x[MSB] ^ y[MSB]) & (x[MSB] ^ d[MSB]);
  endfunction

  logic [DW:0]   wide;
  logic [DW-1:0] diff;

  always_comb begin
    wide  = sub_ext(a, b, cin);
    diff  = wide[DW-1:0];
    res.n = diff[MSB];
    res.z = (diff == '0);
    res.c = wide[DW];
    res.v = sub_ovf(a, b, diff);
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_nzc,
  input  logic            wr_v,
  input  logic            set_ovf,
  input  cfu_pkg::flags_t nxt,
  output cfu_pkg::flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_nzc) begin
        q.n <= nxt.n;
        q.z <= nxt.z;
        q.c <= nxt.c;
      end
      if (set_ovf)   q.v <= 1'b1;
      else if (wr_v) q.v <= nxt.v;
    end
  end

  // R7: the pin wins over any V write
  p_pin_sets_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> q.v);

  // R11: no write request leaves the register untouched
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_nzc && !wr_v && !set_ovf) |=> $stable(q));
endmodule

// File: rtl/cfu_branch_eval.sv
module cfu_branch_eval (
  input  cfu_pkg::flags_t f,
  output logic            ult,
  output logic            uge,
  output logic            slt,
  output logic            sge,
  output logic            sle,
  output logic            sgt
);
  logic lt_s;
  logic le_s;

  always_comb begin
    lt_s = f.n ^ f.v;
    le_s = lt_s | f.z;
    ult  = ~f.c;
    uge  = f.c;
    slt  = lt_s;
    sge  = ~lt_s;
    sle  = le_s;
    sgt  = ~le_s;
  end

  // R9: strictly-less must imply less-or-equal; R8/R9 exclusivity
  always_comb begin
    a_slt_in_sle_r9: assert (!slt || sle);
    a_sgt_in_sge_r8: assert (!sgt || sge);
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          carry_in,
  input  logic          ovf_on_acc_cmp,
  input  logic          set_ovf,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c,
  output logic          br_ult,
  output logic          br_uge,
  output logic          br_slt,
  output logic          br_sge,
  output logic          br_sle,
  output logic          br_sgt
);
  import cfu_pkg::*;

  // decoded events, named for the assertions
  logic   is_acc_cmp, is_idx_cmp, is_sub, is_sgn_cmp, is_cmp;
  logic   wr_nzc, wr_v, cin_eff;
  flags_t nxt_flags, cur_flags;

  always_comb begin
    is_acc_cmp = op_valid && (op_class == OP_CMP_ACC);
    is_idx_cmp = op_valid && ((op_class == OP_CMP_X) || (op_class == OP_CMP_Y));
    is_sub     = op_valid && (op_class == OP_SUB_BRW);
    is_sgn_cmp = op_valid && (op_class == OP_CMP_SGN);
    is_cmp     = is_acc_cmp || is_idx_cmp || is_sgn_cmp;
    wr_nzc     = is_cmp || is_sub;
    wr_v       = is_sub || is_sgn_cmp || (is_acc_cmp && ovf_on_acc_cmp);
    cin_eff    = is_cmp ? 1'b1 : carry_in;
  end

  cfu_sub_core #(.DW(DW)) u_core (
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (cin_eff),
    .res (nxt_flags)
  );

  cfu_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_nzc  (wr_nzc),
    .wr_v    (wr_v),
    .set_ovf (set_ovf),
    .nxt     (nxt_flags),
    .q       (cur_flags)
  );

  cfu_branch_eval u_br (
    .f   (cur_flags),
    .ult (br_ult),
    .uge (br_uge),
    .slt (br_slt),
    .sge (br_sge),
    .sle (br_sle),
    .sgt (br_sgt)
  );

  assign flag_n = cur_flags.n;
  assign flag_v = cur_flags.v;
  assign flag_z = cur_flags.z;
  assign flag_c = cur_flags.c;

  // R1: equality alone decides Z after a compare
  p_cmp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> (flag_z == ($past(opnd_a) == $past(opnd_b))));

  // R2: carry is unsigned greater-or-equal, regardless of carry_in
  p_cmp_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))));

  // R3: legacy accumulator compare keeps V
  p_legacy_keeps_v_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_acc_cmp && !ovf_on_acc_cmp && !set_ovf) |=> (flag_v == $past(flag_v)));

  // R4: a V-writing compare gives true signed ordering through N xor V
  p_signed_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_sgn_cmp || (is_acc_cmp && ovf_on_acc_cmp)) && !set_ovf) |=>
      ((flag_n ^ flag_v) == ($signed($past(opnd_a)) < $signed($past(opnd_b)))));

  // R5: index compares never touch V
  p_idx_keeps_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idx_cmp && !set_ovf) |=> (flag_v == $past(flag_v)));
endmodule

// File: tb/cmp_flag_unit_test.sv
module cmp_flag_unit_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_class;
  logic [7:0] opnd_a, opnd_b;
  logic       carry_in, ovf_on_acc_cmp, set_ovf;
  logic       flag_n, flag_v, flag_z, flag_c;
  logic       br_ult, br_uge, br_slt, br_sge, br_sle, br_sgt;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cmp_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .ovf_on_acc_cmp(ovf_on_acc_cmp), .set_ovf(set_ovf),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
    .br_ult(br_ult), .br_uge(br_uge), .br_slt(br_slt), .br_sge(br_sge),
    .br_sle(br_sle), .br_sgt(br_sgt)
  );

  // {op[25:23], a[22:15], b[14:7], cin[6], cfg[5], prior_v[4], exp nvzc[3:0]}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 8'h50, 8'h30, 1'b0, 1'b0, 1'b1, 4'b0101},
    {3'd0, 8'h30, 8'h50, 1'b1, 1'b0, 1'b0, 4'b1000},
    {3'd0, 8'h42, 8'h42, 1'b0, 1'b0, 1'b1, 4'b0111},
    {3'd0, 8'h50, 8'hB0, 1'b0, 1'b1, 1'b0, 4'b1100},
    {3'd0, 8'h10, 8'h20, 1'b0, 1'b1, 1'b1, 4'b1000},
    {3'd1, 8'h80, 8'h01, 1'b0, 1'b1, 1'b0, 4'b0001},
    {3'd2, 8'h20, 8'h10, 1'b0, 1'b0, 1'b1, 4'b0101},
    {3'd3, 8'h50, 8'h30, 1'b0, 1'b0, 1'b1, 4'b0001},
    {3'd3, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 4'b1000},
    {3'd3, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0, 4'b0101},
    {3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000},
    {3'd4, 8'h7F, 8'hFF, 1'b0, 1'b0, 1'b0, 4'b1100},
    {3'd4, 8'h05, 8'h05, 1'b0, 1'b0, 1'b1, 4'b0011},
    {3'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 4'b0011}
  };

  function automatic string req_of(input logic [2:0] op, input logic cfg);
    if (op == 3'd0) return cfg ? "R4" : "R3";
    if (op == 3'd1 || op == 3'd2) return "R5";
    if (op == 3'd3) return "R6";
    return "R4";
  endfunction

  // {ult, uge, slt, sge, sle, sgt} from {n,v,z,c}
  function automatic logic [5:0] br_expect(input logic [3:0] f);
    logic lt, le;
    lt = f[3] != f[2];
    le = lt || f[1];
    return {!f[0], f[0], lt, !lt, le, !le};
  endfunction

  task automatic check_flags(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    logic [5:0] bact, bexp;
    act  = {flag_n, flag_v, flag_z, flag_c};
    bact = {br_ult, br_uge, br_slt, br_sge, br_sle, br_sgt};
    bexp = br_expect(exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s flags nvzc act=%b exp=%b", tag, act, exp);
    end
    checks++;
    if (bact !== bexp) begin
      failures++;
      $display("FAIL R8 R9 R10 branches (%s) act=%b exp=%b", tag, bact, bexp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic cfg, input logic pin, input logic vld);
    @(negedge clk);
    op_valid = vld; op_class = op; opnd_a = a; opnd_b = b;
    carry_in = cin; ovf_on_acc_cmp = cfg; set_ovf = pin;
    @(negedge clk);
    op_valid = 1'b0; set_ovf = 1'b0;
  endtask

  task automatic preset_v(input logic pv);
    if (pv) issue(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    else    issue(3'd3, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_class = 3'd0; opnd_a = '0; opnd_b = '0;
    carry_in = 1'b0; ovf_on_acc_cmp = 1'b0; set_ovf = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check_flags(4'b0000, "R11 reset");
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      preset_v(e[4]);
      issue(e[25:23], e[22:15], e[14:7], e[6], e[5], 1'b0, 1'b1);
      check_flags(e[3:0], $sformatf("R1 R2 %s vec%0d", req_of(e[25:23], e[5]), i));
    end

    // R7: pin beats a V-clearing subtract in the same cycle; 0x50-0x30 = 0x20
    preset_v(1'b0);
    issue(3'd3, 8'h50, 8'h30, 1'b1, 1'b0, 1'b1, 1'b1);
    check_flags(4'b0101, "R7 pin priority");

    // R7: pin alone, other flags untouched (previous 0101)
    preset_v(1'b0);          // flags now 0011
    issue(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check_flags(4'b0111, "R7 pin alone");

    // R11: reserved class holds flags (currently 0111)
    issue(3'd6, 8'h01, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1);
    check_flags(4'b0111, "R11 reserved class");

    // R11: op_valid low holds flags
    issue(3'd3, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    check_flags(4'b0111, "R11 invalid op");

    // R1: compare ignores carry_in low (0x33-0x33 equal, C=1)
    issue(3'd1, 8'h33, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
    check_flags(4'b0111, "R1 carry ignored");

    // R9: N^V=0, Z=0 -> sgt; signed compare 0x01 vs 0x80 (1 > -128): 0x81, V=1, N=1, C=0
    issue(3'd4, 8'h01, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1);
    check_flags(4'b1100, "R9 R4 signed gt");

    // R11: reset mid-run clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_flags(4'b0000, "R11 reset mid-run");
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule